// File: doc/BRIEF.md
# Transmit PLL Switch Sequencer

This block moves one transceiver channel from its current transmit PLL to another one by way of a memory-mapped reconfiguration bus. A caller raises a start strobe together with a 2-bit logical PLL index. The sequencer reads the lookup register that holds the mapping for that logical PLL and keeps the 4-bit nibble that belongs to the index. It then shuffles that nibble into an 8-bit selection code and writes the code to the channel's PLL selection multiplexer register.

Every bus access holds its strobe until the slave drops waitrequest. A read finishes when readdatavalid pulses. The block reports completion with a one-cycle done pulse. An index at or above the configured number of exposed PLLs gets a one-cycle error pulse instead, and the bus stays untouched. The last code written stays visible on an output.

Top module: `txpll_switch_seq`

## Requirements
- R1: After a synchronous active-high reset, bus_rd_o, bus_wr_o, busy_o, done_o and err_o are all low.
- R2: The read goes to address 0x117 for logical indices 0 and 1, and to 0x118 for indices 2 and 3. Even indices use readdata bits [3:0] and odd indices use bits [7:4].
- R3: For nibble n, the selection code is {~n[3], n[1], n[0], n[3], n[3:0]}, with bit 7 leftmost.
- R4: After the read completes, exactly one write goes to address 0x111. Its writedata[7:0] equals the selection code and writedata[31:8] is zero.
- R5: A read or write strobe stays high, with a steady address, until a cycle in which waitrequest is low. Read and write are never high together. Each switch makes exactly one accepted read and one accepted write.
- R6: When start arrives in idle with an index greater than or equal to NUM_PLLS, err_o is high for exactly the next cycle. No bus strobe rises and busy_o stays low.
- R7: A start that arrives while busy_o is high is ignored. The code written and the number of accesses come from the first request only.
- R8: busy_o is high from the cycle after an accepted start through the done cycle. done_o is high for exactly one cycle.
- R9: sel_code_o shows the code that was written, and it holds that value after done.
- R10: With a waitrequest stall of L cycles on each access, done_o becomes visible 5+2L cycles after the edge that samples start.

Top module parameters: NUM_PLLS (1 to 4, default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a PLL switch |
| pll_idx_i | input | 2 | Logical PLL index to switch to |
| busy_o | output | 1 | Switch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a rejected index |
| sel_code_o | output | 8 | Last selection code written |
| bus_addr_o | output | 10 | Bus address |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data |
| bus_rvalid_i | input | 1 | Read data valid pulse |
| bus_wait_i | input | 1 | Slave waitrequest |

## Verification
Each switch takes five register stages plus two waitrequest stalls of L cycles. So the bench counts falling edges from the edge that samples start and expects done exactly at 5+2L. It also expects busy already high at the first count. The error pulse is due one cycle after start. The bench samples err_o there and again one cycle later, then watches the bus-model access counters for several more cycles to confirm that no access happened. All samples are taken on falling edges, while inputs change only there.

// File: rtl/txpll_switch_pkg.sv
package txpll_switch_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int CODE_W = 8;
    localparam int NIB_W  = 4;

    localparam logic [ADDR_W-1:0] LUT_BASE_ADDR = 10'h117;
    localparam logic [ADDR_W-1:0] SEL_MUX_ADDR  = 10'h111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_REQ,
        ST_READ_WAIT,
        ST_ENCODE,
        ST_WRITE_REQ,
        ST_DONE
    } seq_state_e;

    // Lookup register that holds the mapping for a logical index
    function automatic logic [ADDR_W-1:0] lut_addr(input logic [1:0] idx);
        return LUT_BASE_ADDR + ADDR_W'(idx[1]);
    endfunction

    // Bit shuffle from lookup nibble to multiplexer selection code
    function automatic logic [CODE_W-1:0] shuffle_code(input logic [NIB_W-1:0] n);
        return {~n[3], n[1:0], n[3], n};
    endfunction

endpackage

// File: rtl/txpll_seq_ctrl.sv
module txpll_seq_ctrl
    import txpll_switch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       idx_ok_i,
    input  logic       bus_wait_i,
    input  logic       bus_rvalid_i,
    output seq_state_e state_o
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i && idx_ok_i) state_d = ST_READ_REQ;
            ST_READ_REQ:  if (!bus_wait_i)         state_d = ST_READ_WAIT;
            ST_READ_WAIT: if (bus_rvalid_i)        state_d = ST_ENCODE;
            ST_ENCODE:                             state_d = ST_WRITE_REQ;
            ST_WRITE_REQ: if (!bus_wait_i)         state_d = ST_DONE;
            ST_DONE:                               state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/txpll_sel_encoder.sv
module txpll_sel_encoder
    import txpll_switch_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES*NIB_W-1:0] word_i,
    input  logic [$clog2(LANES)-1:0] lane_i,
    output logic [CODE_W-1:0]      code_o
);

    logic [CODE_W-1:0] lane_code [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_code[g] = shuffle_code(word_i[g*NIB_W +: NIB_W]);
    end

    assign code_o = lane_code[lane_i];

endmodule

// File: rtl/txpll_switch_seq.sv
module txpll_switch_seq
    import txpll_switch_pkg::*;
#(
    parameter int NUM_PLLS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        pll_idx_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CODE_W-1:0] sel_code_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_rvalid_i,
    input  logic              bus_wait_i
);

    localparam int          LANES   = 2;
    localparam int          LUT_W   = LANES * NIB_W;
    localparam logic [2:0]  NUM_LIM = 3'(NUM_PLLS);

    seq_state_e        state;
    logic              idx_ok;
    logic [1:0]        idx_q;
    logic [LUT_W-1:0]  lut_q;
    logic [CODE_W-1:0] code_d, code_q;
    logic              err_q;
    logic              unused_rdata_hi;

    assign idx_ok          = {1'b0, pll_idx_i} < NUM_LIM;
    assign unused_rdata_hi = ^bus_rdata_i[DATA_W-1:LUT_W];

    txpll_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .idx_ok_i     (idx_ok),
        .bus_wait_i   (bus_wait_i),
        .bus_rvalid_i (bus_rvalid_i),
        .state_o      (state)
    );

    txpll_sel_encoder #(.LANES(LANES)) u_enc (
        .word_i (lut_q),
        .lane_i (idx_q[0]),
        .code_o (code_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            lut_q  <= '0;
            code_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= (state == ST_IDLE) && start_i && !idx_ok;
            if (state == ST_IDLE && start_i && idx_ok)
                idx_q <= pll_idx_i;
            if (state == ST_READ_WAIT && bus_rvalid_i)
                lut_q <= bus_rdata_i[LUT_W-1:0];
            if (state == ST_ENCODE)
                code_q <= code_d;
        end
    end

    assign bus_rd_o    = (state == ST_READ_REQ);
    assign bus_wr_o    = (state == ST_WRITE_REQ);
    assign bus_addr_o  = (state == ST_WRITE_REQ) ? SEL_MUX_ADDR : lut_addr(idx_q);
    assign bus_wdata_o = {{(DATA_W-CODE_W){1'b0}}, code_q};
    assign busy_o      = (state != ST_IDLE);
    assign done_o      = (state == ST_DONE);
    assign err_o       = err_q;
    assign sel_code_o  = code_q;

endmodule

// File: rtl/txpll_switch_chk.sv
module txpll_switch_chk
    import txpll_switch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_rd_o,
    input logic              bus_wr_o,
    input logic              bus_wait_i
);

    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd_o && bus_wr_o));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_o && bus_wait_i) |=> (bus_rd_o && $stable(bus_addr_o)));

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_o && bus_wait_i) |=> (bus_wr_o && $stable(bus_addr_o)));

    // R2
    rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd_o |-> (bus_addr_o == 10'h117 || bus_addr_o == 10'h118));

    // R4
    wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr_o |-> (bus_addr_o == 10'h111));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!bus_rd_o && !bus_wr_o && !busy_o));

    // R6
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

endmodule

bind txpll_switch_seq txpll_switch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .bus_addr_o (bus_addr_o),
    .bus_rd_o   (bus_rd_o),
    .bus_wr_o   (bus_wr_o),
    .bus_wait_i (bus_wait_i)
);

// File: tb/txpll_switch_seq_tb.sv
module txpll_switch_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TB_PLLS    = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  idx = 2'd0;
    logic        busy, done, err;
    logic [7:0]  code;
    logic [9:0]  addr;
    logic        rd, wr;
    logic [31:0] wdata;
    logic [31:0] rdata = '0;
    logic        rvalid = 1'b0;
    logic        bwait;

    // bus model state
    logic [7:0]  reg117 = 8'h00;
    logic [7:0]  reg118 = 8'h00;
    logic [7:0]  reg111 = 8'h00;
    logic [31:0] last_wdata = '0;
    logic [9:0]  last_rd_addr = '0;
    logic [9:0]  last_wr_addr = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          lat = 0;
    int          wcnt = 0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txpll_switch_seq #(.NUM_PLLS(TB_PLLS)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .pll_idx_i    (idx),
        .busy_o       (busy),
        .done_o       (done),
        .err_o        (err),
        .sel_code_o   (code),
        .bus_addr_o   (addr),
        .bus_rd_o     (rd),
        .bus_wr_o     (wr),
        .bus_wdata_o  (wdata),
        .bus_rdata_i  (rdata),
        .bus_rvalid_i (rvalid),
        .bus_wait_i   (bwait)
    );

    assign bwait = (rd || wr) && (wcnt != lat);

    always @(posedge clk) begin
        rvalid <= 1'b0;
        if ((rd || wr) && !rst) begin
            if (wcnt != lat) begin
                wcnt <= wcnt + 1;
            end else begin
                wcnt <= 0;
                if (rd) begin
                    rd_cnt       <= rd_cnt + 1;
                    last_rd_addr <= addr;
                    rvalid       <= 1'b1;
                    rdata        <= {24'hDEAD5A, (addr == 10'h117) ? reg117 :
                                     (addr == 10'h118) ? reg118 : 8'hEE};
                end
                if (wr) begin
                    wr_cnt       <= wr_cnt + 1;
                    last_wr_addr <= addr;
                    last_wdata   <= wdata;
                    if (addr == 10'h111) reg111 <= wdata[7:0];
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input logic [3:0] n);
        logic [7:0] c;
        c[3:0] = n;
        c[4]   = n[3];
        c[5]   = n[0];
        c[6]   = n[1];
        c[7]   = !n[3];
        return c;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd == 1'b0 && wr == 1'b0, "R1", "strobes after reset", {30'b0, rd, wr}, 0);
        check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
        check(done == 1'b0 && err == 1'b0, "R1", "done/err after reset", {30'b0, done, err}, 0);
    endtask

    task automatic t_switch(input logic [1:0] i, input int l,
                            input logic [7:0] v117, input logic [7:0] v118);
        int r0, w0, k;
        logic [3:0] nib;
        logic [7:0] ec;
        reg117 = v117;
        reg118 = v118;
        lat    = l;
        r0 = rd_cnt;
        w0 = wr_cnt;
        nib = i[1] ? (i[0] ? v118[7:4] : v118[3:0]) : (i[0] ? v117[7:4] : v117[3:0]);
        ec  = exp_code(nib);
        @(negedge clk);
        start = 1'b1;
        idx   = i;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        check(busy == 1'b1, "R8", "busy after start", 32'(busy), 1);
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        check(k == 5 + 2*l, "R10", "cycles to done", k, 5 + 2*l);
        check(busy == 1'b1, "R8", "busy in done cycle", 32'(busy), 1);
        check(last_rd_addr == (i[1] ? 10'h118 : 10'h117), "R2", "lookup address",
              32'(last_rd_addr), i[1] ? 32'h118 : 32'h117);
        check(reg111 == ec, "R3", "code written", 32'(reg111), 32'(ec));
        check(last_wr_addr == 10'h111 && last_wdata[31:8] == 24'h0, "R4",
              "write address/upper data", {last_wdata[31:8], last_wr_addr[7:0]}, 32'h11);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8", "done one cycle, busy drops",
              {30'b0, done, busy}, 0);
        repeat (3) @(negedge clk);
        check(rd_cnt - r0 == 1 && wr_cnt - w0 == 1, "R5", "one read and one write",
              (rd_cnt - r0) * 16 + (wr_cnt - w0), 32'h11);
        check(code == ec, "R9", "code held after done", 32'(code), 32'(ec));
    endtask

    task automatic t_bad_idx();
        int r0, w0;
        logic [7:0] held;
        r0 = rd_cnt;
        w0 = wr_cnt;
        held = code;
        @(negedge clk);
        start = 1'b1;
        idx   = 2'd3;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b1, "R6", "error pulse", 32'(err), 1);
        check(busy == 1'b0, "R6", "busy stays low", 32'(busy), 0);
        @(negedge clk);
        check(err == 1'b0, "R6", "error one cycle", 32'(err), 0);
        repeat (6) @(negedge clk);
        check(rd_cnt == r0 && wr_cnt == w0, "R6", "no bus access",
              (rd_cnt - r0) + (wr_cnt - w0), 0);
        check(code == held, "R6", "code unchanged", 32'(code), 32'(held));
    endtask

    task automatic t_busy_ignore();
        int r0, w0, k;
        logic [7:0] ec;
        reg117 = 8'h3C;
        reg118 = 8'h00;
        lat    = 2;
        r0 = rd_cnt;
        w0 = wr_cnt;
        ec = exp_code(4'hC);
        @(negedge clk);
        start = 1'b1;
        idx   = 2'd0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
        idx   = 2'd1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        repeat (10) @(negedge clk);
        check(rd_cnt - r0 == 1 && wr_cnt - w0 == 1, "R7", "second start ignored",
              (rd_cnt - r0) * 16 + (wr_cnt - w0), 32'h11);
        check(reg111 == ec && code == ec, "R7", "code from first request",
              32'(reg111), 32'(ec));
        check(busy == 1'b0, "R7", "idle after ignored start", 32'(busy), 0);
    endtask

    initial begin
        t_reset();
        t_switch(2'd0, 0, 8'h5A, 8'h00);
        t_switch(2'd1, 0, 8'h9E, 8'h00);
        t_switch(2'd2, 1, 8'h00, 8'h47);
        t_switch(2'd1, 3, 8'h61, 8'hFF);
        t_switch(2'd0, 2, 8'hF8, 8'h12);
        t_bad_idx();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule